// File: doc/BRIEF.md
# Load Data Formatter

This block sits between the data returned by a memory read and the register-file write port of a processor pipeline. It takes up to 64 bits of little-endian load data, together with a description of the access, and shapes it into the value to be written to a destination register or register pair. Byte 0 of the load data is bits 7:0.

Five kinds of load are handled:

- **Plain loads** of a byte, halfword, word or doubleword, with sign or zero extension for the two short sizes.
- **Two spreading loads** that place each loaded byte into its own 16-bit lane.
- **Two alignment loads** that shift the old register pair down and insert the new byte or halfword at its top.

A load can be made conditional on a one-bit predicate. The predicate may be taken from its old or its newly produced value, and may be inverted. A load whose condition is false is cancelled, and its result is forced to zero.

The shaping logic is combinational and feeds one output register. A request presented with `req_valid` high at a clock edge gives its result on `res_data` from that edge onward, with `res_valid` high for one cycle.

Top module: `ldfmt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid`, `res_cancel` and `res_data` become 0.
- R2: `res_valid` equals `req_valid` from the previous clock edge. When `req_valid` was low, `res_data` keeps its value.
- R3: Plain load (op 0), size 0 (byte) or 1 (halfword): the low 8 or 16 bits of `mem_data` are sign-extended to 64 bits when `sign_ext` is 1, and zero-extended otherwise.
- R4: Plain load, size 2 (word): the result is `mem_data[31:0]` with bits 63:32 zero, whatever `sign_ext` is. Size 3 (doubleword): the result is `mem_data` unchanged.
- R5: Spread-2 (op 1): byte i of `mem_data` (i = 0, 1) is extended to 16 bits according to `sign_ext` and placed in bits 16i+15:16i. Bits 63:32 are zero.
- R6: Spread-4 (op 2): byte i (i = 0..3) is extended to 16 bits according to `sign_ext` and placed in bits 16i+15:16i of the 64-bit result.
- R7: Halfword align (op 3): the result is `old_pair` shifted right by 16, with `mem_data[15:0]` in bits 63:48.
- R8: Byte align (op 4): the result is `old_pair` shifted right by 8, with `mem_data[7:0]` in bits 63:56.
- R9: When `pred_en` is 1, the condition is the predicate selected by `pred_use_new` (1 selects `pred_new`, 0 selects `pred_old`), XOR `pred_invert`. When the condition is 0, the result is 0 and `res_cancel` is 1. When `pred_en` is 0, the load always executes.
- R10: Op codes 5, 6 and 7 give a result of 0.
- R11: Bits of `mem_data` above the access width do not affect the result of plain, spread or align loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load result is presented this cycle |
| op | input | 3 | 0 plain, 1 spread-2, 2 spread-4, 3 halfword align, 4 byte align |
| size | input | 2 | Plain load size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| sign_ext | input | 1 | 1 sign-extends, 0 zero-extends |
| mem_data | input | 64 | Little-endian data returned by memory |
| old_pair | input | 64 | Previous value of the destination register pair |
| pred_en | input | 1 | Load is conditional on a predicate |
| pred_old | input | 1 | Least significant bit of the old predicate value |
| pred_new | input | 1 | Least significant bit of the newly produced predicate value |
| pred_use_new | input | 1 | Select `pred_new` instead of `pred_old` |
| pred_invert | input | 1 | Execute when the selected predicate is false |
| res_valid | output | 1 | Registered result strobe |
| res_cancel | output | 1 | The load was cancelled by its predicate |
| res_data | output | 64 | Value to write back |

## Verification
The assertions assume that `req_valid` is low during the cycle in which reset is released, because the latency and hold properties look one cycle back. The assertions also assume that `op`, `old_pair` and the predicate inputs are defined whenever `req_valid` is high.

The stimulus meets both assumptions:

- It holds every input at zero through reset.
- It drives all fields only at the falling edge.
- It drops `req_valid` between requests, so that the hold behaviour is observed on the output.

Load data deliberately carries non-zero bytes above each access width, so that any leakage of unused bits shows at the port.

// File: rtl/ldfmt_pkg.sv
// Shared widths and encodings for the load data formatter.
// Assumes little-endian load data.
package ldfmt_pkg;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 2 * BYTE_W;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int DATA_W   = 2 * WORD_W;
    localparam int SPREAD_N = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_SPREAD2 = 3'd1,
        OP_SPREAD4 = 3'd2,
        OP_ALIGN_H = 3'd3,
        OP_ALIGN_B = 3'd4
    } ld_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } ld_size_e;
endpackage

// File: rtl/ldfmt_extend.sv
// Plain-load extension.
// Picks the low byte, halfword, word or the whole doubleword of the
// load data, and sign- or zero-extends the two short sizes to DATA_W.
// Words are always zero-extended.
// Assumes: combinational; the caller registers the result.
module ldfmt_extend
    import ldfmt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] mem,
    input  logic [1:0]    size,
    input  logic          sgn,
    output logic [DW-1:0] result
);
    localparam int BW = BYTE_W;
    localparam int HW = HALF_W;
    localparam int WW = WORD_W;

    // Select the access width and apply the extension rule.
    always_comb begin
        unique case (ld_size_e'(size))
            SZ_BYTE:  result = {{(DW-BW){sgn & mem[BW-1]}}, mem[BW-1:0]};
            SZ_HALF:  result = {{(DW-HW){sgn & mem[HW-1]}}, mem[HW-1:0]};
            SZ_WORD:  result = {{(DW-WW){1'b0}}, mem[WW-1:0]};
            default:  result = mem;
        endcase
    end
endmodule

// File: rtl/ldfmt_spread.sv
// Byte-to-halfword spreading.
// Byte i of the input goes to 16-bit lane i, extended according to sgn.
// With wide low only lanes 0 and 1 are filled; the upper lanes read zero.
// Assumes: LANES is even and at least 2.
module ldfmt_spread
    import ldfmt_pkg::*;
#(
    parameter int LANES = SPREAD_N
) (
    input  logic [LANES*BYTE_W-1:0] bytes_in,
    input  logic                    sgn,
    input  logic                    wide,
    output logic [LANES*HALF_W-1:0] result
);
    localparam int NARROW = 2;
    localparam int PAD    = HALF_W - BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] b;
        logic [HALF_W-1:0] ext;
        logic              live;

        // Per-lane extension of one byte to a halfword.
        always_comb begin
            b    = bytes_in[g*BYTE_W +: BYTE_W];
            ext  = {{PAD{sgn & b[BYTE_W-1]}}, b};
            live = (g < NARROW) || wide;
        end

        assign result[g*HALF_W +: HALF_W] = live ? ext : '0;
    end
endmodule

// File: rtl/ldfmt_align.sv
// Shift-in alignment.
// Shifts the old register pair down by a byte or a halfword and inserts
// the new data at the top.
// Assumes: only old bits above the byte shift are supplied.
module ldfmt_align
    import ldfmt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [HALF_W-1:0] mem,
    input  logic [DW-1:BYTE_W] old_hi,
    input  logic              half,
    output logic [DW-1:0]     result
);
    // Choose the shift amount and insert the new data above the old pair.
    always_comb begin
        if (half) result = {mem, old_hi[DW-1:HALF_W]};
        else      result = {mem[BYTE_W-1:0], old_hi};
    end
endmodule

// File: rtl/ldfmt_pred_gate.sv
// Predicate evaluation.
// Decides whether a load executes: the old or new predicate bit is
// selected and optionally inverted. An unconditional load always passes.
// Assumes: predicate inputs are the least significant bit only.
module ldfmt_pred_gate (
    input  logic en,
    input  logic p_old,
    input  logic p_new,
    input  logic use_new,
    input  logic invert,
    output logic pass
);
    logic chosen;

    // Select, optionally invert, and bypass when unconditional.
    always_comb begin
        chosen = use_new ? p_new : p_old;
        pass   = !en || (chosen ^ invert);
    end
endmodule

// File: rtl/ldfmt_top.sv
// Load data formatter top.
// Routes load data through the plain, spread and align shapers, selects
// by op, zeroes cancelled or reserved results, and registers the outcome
// with a valid strobe.
// Assumes: synchronous active-low reset; req_valid is low in the cycle
// in which reset is released.
module ldfmt_top
    import ldfmt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    op,
    input  logic [1:0]    size,
    input  logic          sign_ext,
    input  logic [DW-1:0] mem_data,
    input  logic [DW-1:0] old_pair,
    input  logic          pred_en,
    input  logic          pred_old,
    input  logic          pred_new,
    input  logic          pred_use_new,
    input  logic          pred_invert,
    output logic          res_valid,
    output logic          res_cancel,
    output logic [DW-1:0] res_data
);
    localparam int SPREAD_W = SPREAD_N * HALF_W;
    localparam int SBYTES_W = SPREAD_N * BYTE_W;

    logic [DW-1:0]       plain_res;
    logic [SPREAD_W-1:0] spread_res;
    logic [DW-1:0]       align_res;
    logic [DW-1:0]       shaped;
    logic                pass;

    ldfmt_extend #(.DW(DW)) u_extend (
        .mem    (mem_data),
        .size   (size),
        .sgn    (sign_ext),
        .result (plain_res)
    );

    ldfmt_spread #(.LANES(SPREAD_N)) u_spread (
        .bytes_in (mem_data[SBYTES_W-1:0]),
        .sgn      (sign_ext),
        .wide     (op == OP_SPREAD4),
        .result   (spread_res)
    );

    ldfmt_align #(.DW(DW)) u_align (
        .mem    (mem_data[HALF_W-1:0]),
        .old_hi (old_pair[DW-1:BYTE_W]),
        .half   (op == OP_ALIGN_H),
        .result (align_res)
    );

    ldfmt_pred_gate u_gate (
        .en      (pred_en),
        .p_old   (pred_old),
        .p_new   (pred_new),
        .use_new (pred_use_new),
        .invert  (pred_invert),
        .pass    (pass)
    );

    // Pick the shaper that matches the op; reserved codes give zero.
    always_comb begin
        case (op)
            OP_PLAIN:               shaped = plain_res;
            OP_SPREAD2, OP_SPREAD4: shaped = {{(DW-SPREAD_W){1'b0}}, spread_res};
            OP_ALIGN_H, OP_ALIGN_B: shaped = align_res;
            default:                shaped = '0;
        endcase
    end

    // Output register: strobe every cycle, data only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_cancel <= 1'b0;
            res_data   <= '0;
        end else begin
            res_valid  <= req_valid;
            res_cancel <= req_valid && !pass;
            if (req_valid) res_data <= pass ? shaped : '0;
        end
    end

    // R2: the strobe follows the request by one cycle.
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid));

    // R2: without a request the output data holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_data));

    // R9: a cancelled result is always zero and comes with the strobe.
    p_cancel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_cancel |-> (res_valid && res_data == '0));

    // R9: a failing predicate is reported as a cancellation.
    p_cancel_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pred_en && !((pred_use_new ? pred_new : pred_old) ^ pred_invert))
        |=> res_cancel);

    // R5: a spread-2 result has an empty upper word.
    p_spread2_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_SPREAD2) |=> res_data[DW-1:WORD_W] == '0);

    // R7: halfword align keeps the old pair shifted down by 16.
    p_align_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pass && op == OP_ALIGN_H)
        |=> res_data[DW-HALF_W-1:0] == $past(old_pair[DW-1:HALF_W]));

    // R8: byte align puts the new byte on top.
    p_align_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pass && op == OP_ALIGN_B)
        |=> res_data[DW-1:DW-BYTE_W] == $past(mem_data[BYTE_W-1:0]));
endmodule

// File: tb/ldfmt_top_tb_top.sv
`timescale 1ns/1ps
module ldfmt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic        sign_ext = 1'b0;
    logic [63:0] mem_data = '0;
    logic [63:0] old_pair = '0;
    logic        pred_en = 1'b0, pred_old = 1'b0, pred_new = 1'b0;
    logic        pred_use_new = 1'b0, pred_invert = 1'b0;
    logic        res_valid, res_cancel;
    logic [63:0] res_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ldfmt_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .size(size),
        .sign_ext(sign_ext), .mem_data(mem_data), .old_pair(old_pair),
        .pred_en(pred_en), .pred_old(pred_old), .pred_new(pred_new),
        .pred_use_new(pred_use_new), .pred_invert(pred_invert),
        .res_valid(res_valid), .res_cancel(res_cancel), .res_data(res_data)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  size;
        logic        sgn;
        logic [63:0] mem;
        logic [63:0] old;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R3, R11: signed byte, upper bytes must be ignored
        '{4'd3, 3'd0, 2'd0, 1'b1, 64'hDEADBEEF_CAFE1280, 64'h0, 64'hFFFFFFFF_FFFFFF80},
        // R3: unsigned byte
        '{4'd3, 3'd0, 2'd0, 1'b0, 64'hDEADBEEF_CAFE1280, 64'h0, 64'h00000000_00000080},
        // R3: signed halfword
        '{4'd3, 3'd0, 2'd1, 1'b1, 64'h11112222_33339ABC, 64'h0, 64'hFFFFFFFF_FFFF9ABC},
        // R3: unsigned halfword
        '{4'd3, 3'd0, 2'd1, 1'b0, 64'h11112222_33339ABC, 64'h0, 64'h00000000_00009ABC},
        // R4: word, sign flag has no effect
        '{4'd4, 3'd0, 2'd2, 1'b1, 64'hAAAABBBB_87654321, 64'h0, 64'h00000000_87654321},
        // R4: doubleword
        '{4'd4, 3'd0, 2'd3, 1'b0, 64'h01234567_89ABCDEF, 64'h0, 64'h01234567_89ABCDEF},
        // R5: spread-2 unsigned
        '{4'd5, 3'd1, 2'd0, 1'b0, 64'hFFFFFFFF_FFFF807F, 64'h0, 64'h00000000_0080007F},
        // R5: spread-2 signed
        '{4'd5, 3'd1, 2'd0, 1'b1, 64'hFFFFFFFF_FFFF807F, 64'h0, 64'h00000000_FF80007F},
        // R6: spread-4 unsigned
        '{4'd6, 3'd2, 2'd0, 1'b0, 64'h55555555_01FE807F, 64'h0, 64'h000100FE_0080007F},
        // R6: spread-4 signed
        '{4'd6, 3'd2, 2'd0, 1'b1, 64'h55555555_01FE807F, 64'h0, 64'h0001FFFE_FF80007F},
        // R7: halfword align
        '{4'd7, 3'd3, 2'd0, 1'b1, 64'hFFFFFFFF_FFFFABCD, 64'h11223344_55667788, 64'hABCD1122_33445566},
        // R8: byte align
        '{4'd8, 3'd4, 2'd0, 1'b0, 64'hFFFFFFFF_FFFFFF9E, 64'h11223344_55667788, 64'h9E112233_44556677},
        // R10: reserved op code 5
        '{4'd10, 3'd5, 2'd3, 1'b0, 64'h01234567_89ABCDEF, 64'h11223344_55667788, 64'h0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle, then sample after the capturing edge.
    task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic sg,
                         input logic [63:0] m, input logic [63:0] old);
        @(negedge clk);
        req_valid = 1'b1; op = o; size = s; sign_ext = sg; mem_data = m; old_pair = old;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_pred(input logic en, input logic po, input logic pn,
                            input logic un, input logic inv);
        pred_en = en; pred_old = po; pred_new = pn; pred_use_new = un; pred_invert = inv;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_valid", {63'd0, res_valid}, 64'd0);
        check("R1 res_cancel", {63'd0, res_cancel}, 64'd0);
        check("R1 res_data", res_data, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].size, VECS[i].sgn, VECS[i].mem, VECS[i].old);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), res_data, VECS[i].exp);
            check($sformatf("R2 valid vector %0d", i), {63'd0, res_valid}, 64'd1);
        end

        // R2: hold with no request, strobe drops.
        held = res_data;
        mem_data = 64'hFFFF_FFFF_FFFF_FFFF;
        op = 3'd0;
        size = 2'd3;
        @(negedge clk);
        check("R2 strobe low", {63'd0, res_valid}, 64'd0);
        check("R2 hold data", res_data, held);

        // R9: old predicate true executes.
        set_pred(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0);
        check("R9 old true data", res_data, 64'h0123_4567_89AB_CDEF);
        check("R9 old true no cancel", {63'd0, res_cancel}, 64'd0);

        // R9: old predicate false cancels.
        set_pred(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        issue(3'd0, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0);
        check("R9 old false data", res_data, 64'h0);
        check("R9 old false cancel", {63'd0, res_cancel}, 64'd1);

        // R9: inverted false predicate executes.
        set_pred(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        issue(3'd0, 2'd0, 1'b1, 64'h0000_0000_0000_00F0, 64'h0);
        check("R9 invert data", res_data, 64'hFFFF_FFFF_FFFF_FFF0);
        check("R9 invert no cancel", {63'd0, res_cancel}, 64'd0);

        // R9: new predicate selected (false) even though old is true.
        set_pred(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        issue(3'd4, 2'd0, 1'b0, 64'h9E, 64'h1122_3344_5566_7788);
        check("R9 new false align data", res_data, 64'h0);
        check("R9 new false cancel", {63'd0, res_cancel}, 64'd1);

        // R9: new predicate true with old false executes.
        set_pred(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        issue(3'd3, 2'd0, 1'b0, 64'hABCD, 64'h1122_3344_5566_7788);
        check("R9 new true align", res_data, 64'hABCD_1122_3344_5566);

        // R9: unconditional load ignores false predicates.
        set_pred(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(3'd2, 2'd0, 1'b0, 64'h0403_0201, 64'h0);
        check("R9 unconditional", res_data, 64'h0004_0003_0002_0001);
        check("R9 unconditional no cancel", {63'd0, res_cancel}, 64'd0);

        // R11: spread-2 ignores bytes 2 and up.
        issue(3'd1, 2'd0, 1'b1, 64'h8080_8080_8080_0102, 64'h0);
        check("R11 spread2 upper bytes ignored", res_data, 64'h0000_0000_0001_0002);

        // R1: reset mid-run clears the output.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears data", res_data, 64'd0);
        check("R1 reset clears strobe", {63'd0, res_valid}, 64'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule